// File: doc/BRIEF.md
# Dual-Source Timer Prescaler

This block turns raw timing strobes into the tick enable that drives one half of a countdown timer. Two strobe sources reach it, both already in the system clock domain. One comes from the fast system oscillator and the other from a 32768 Hz low-power oscillator. A select bit picks one source, and a 3-bit scale code picks one of eight divide ratios. The ratio set depends on the source: the fast set is uneven and the slow set is powers of two.

A tick needs three things: the prescaler's own run enable, the group enable of the selected oscillator, and a strobe from that source. An internal counter counts the qualifying strobes. On the strobe that completes a period, the block raises a one-cycle tick in the next cycle. When the source or the scale code changes, the counter restarts from zero, so the first tick after a change comes one full period later.

Top module: `tmr_prescale`

## Requirements
- R1: After reset, `tick` is low and the prescale count is zero, so the first tick needs a full period of strobes.
- R2: With `src_sel` = 0 (fast source), scale codes 0, 1, 2, 3, 4, 5, 6 and 7 give one tick per 2, 8, 32, 64, 128, 256, 1024 and 4096 qualifying strobes respectively.
- R3: With `src_sel` = 1 (slow source), scale code n gives one tick per 2^n qualifying strobes. Code 0 passes every strobe through as a tick.
- R4: A tick is high for exactly one cycle. It appears in the cycle after the strobe that completes a period. A strobe held high under divide-by-1 gives a tick in every cycle.
- R5: While `run_en` is low, no tick is produced and the count is cleared.
- R6: While the group enable of the selected source is low, that source's strobes are ignored and the count holds its value. When the group enable is set again, counting resumes from the held value.
- R7: Strobes from the source that is not selected have no effect.
- R8: Any change of `src_sel` or `scale` clears the count, and a strobe in the cycle of the change is not counted. The first tick after a change therefore needs a full period of the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | Source select: 0 fast oscillator, 1 32768 Hz oscillator |
| scale | input | 3 | Divide ratio code |
| run_en | input | 1 | Prescaler enable |
| grp_fast_en | input | 1 | Group enable for the fast oscillator |
| grp_slow_en | input | 1 | Group enable for the slow oscillator |
| fast_stb | input | 1 | Strobe from the fast oscillator, system clock domain |
| slow_stb | input | 1 | Strobe from the slow oscillator, system clock domain |
| tick | output | 1 | One-cycle tick enable |

## Verification
The assertions assume that every input is a known value once reset is released. The ones on tick spacing assume that a configuration change is the only event that can cut a period short. The bench changes its inputs only on the falling clock edge. It makes strobes one-cycle pulses with an idle cycle between them, except in the held-strobe divide-by-1 case. It alters the source or scale only while the strobes are low, so no strobe lands in a change cycle unless a test intends it.

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_sel,
  input  logic [2:0] scale,
  input  logic       run_en,
  input  logic       grp_fast_en,
  input  logic       grp_slow_en,
  input  logic       fast_stb,
  input  logic       slow_stb,
  output logic       tick
);

  localparam int CFG_W = 4;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic [CFG_W-1:0] cfg_q;
  logic [3:0]       lg;
  logic             cfg_chg;
  logic             src_hit;
  logic             stb_ok;
  logic             at_term;

  always_comb begin
    if (src_sel) begin
      lg = {1'b0, scale};
    end else begin
      case (scale)
        3'd0:    lg = 4'd1;
        3'd1:    lg = 4'd3;
        3'd2:    lg = 4'd5;
        3'd3:    lg = 4'd6;
        3'd4:    lg = 4'd7;
        3'd5:    lg = 4'd8;
        3'd6:    lg = 4'd10;
        default: lg = 4'd12;
      endcase
    end
    term = (CNT_W'(1) << lg) - CNT_W'(1);
  end

  assign cfg_chg = {src_sel, scale} != cfg_q;
  assign src_hit = src_sel ? (slow_stb && grp_slow_en) : (fast_stb && grp_fast_en);
  assign stb_ok  = run_en && !cfg_chg && src_hit;
  assign at_term = cnt_q == term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
      tick  <= 1'b0;
    end else begin
      cfg_q <= {src_sel, scale};
      tick  <= stb_ok && at_term;
      if (!run_en || cfg_chg)
        cnt_q <= '0;
      else if (stb_ok)
        cnt_q <= at_term ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R5
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !tick);

  // R6
  grp_fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel && !grp_fast_en) |=> !tick);

  // R6
  grp_slow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !grp_slow_en) |=> !tick);

  // R7
  sel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(src_sel ? slow_stb : fast_stb));

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || $past(src_sel && scale == 3'd0)));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> cnt_q <= term);

endmodule

// File: tb/tmr_prescale_bench.sv
`timescale 1ns/1ps
module tmr_prescale_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_sel = 1'b0;
  logic [2:0] scale = 3'd0;
  logic run_en = 1'b0;
  logic grp_fast_en = 1'b0;
  logic grp_slow_en = 1'b0;
  logic fast_stb = 1'b0;
  logic slow_stb = 1'b0;
  logic tick;

  int n_chk = 0;
  int n_bad = 0;
  int stray = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_prescale u_tmr_prescale (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .scale(scale),
    .run_en(run_en), .grp_fast_en(grp_fast_en), .grp_slow_en(grp_slow_en),
    .fast_stb(fast_stb), .slow_stb(slow_stb), .tick(tick)
  );

  // {src, scale, strobes, expected ticks, strobe index of first tick}
  localparam logic [32:0] VEC [16] = '{
    {1'b0, 3'd0, 13'd5,    3'd2, 13'd2},
    {1'b0, 3'd1, 13'd17,   3'd2, 13'd8},
    {1'b0, 3'd2, 13'd64,   3'd2, 13'd32},
    {1'b0, 3'd3, 13'd130,  3'd2, 13'd64},
    {1'b0, 3'd4, 13'd128,  3'd1, 13'd128},
    {1'b0, 3'd5, 13'd300,  3'd1, 13'd256},
    {1'b0, 3'd6, 13'd1030, 3'd1, 13'd1024},
    {1'b0, 3'd7, 13'd4100, 3'd1, 13'd4096},
    {1'b1, 3'd0, 13'd2,    3'd2, 13'd1},
    {1'b1, 3'd1, 13'd5,    3'd2, 13'd2},
    {1'b1, 3'd2, 13'd11,   3'd2, 13'd4},
    {1'b1, 3'd3, 13'd23,   3'd2, 13'd8},
    {1'b1, 3'd4, 13'd47,   3'd2, 13'd16},
    {1'b1, 3'd5, 13'd95,   3'd2, 13'd32},
    {1'b1, 3'd6, 13'd191,  3'd2, 13'd64},
    {1'b1, 3'd7, 13'd383,  3'd2, 13'd128}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input logic f, input logic s, output logic t);
    @(negedge clk);
    fast_stb = f;
    slow_stb = s;
    @(negedge clk);
    fast_stb = 1'b0;
    slow_stb = 1'b0;
    t = tick;
    @(negedge clk);
    if (tick) stray++;
  endtask

  task automatic burst(input logic f, input logic s, input int n, output int cnt);
    logic t;
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      pulse(f, s, t);
      if (t) cnt++;
    end
  endtask

  task automatic setup(input logic src, input logic [2:0] sc);
    @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    src_sel = src;
    scale = sc;
    grp_fast_en = 1'b1;
    grp_slow_en = 1'b1;
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tick == 1'b0, "R1 tick after reset", tick, 0);

    // R1 first period after reset is full: fast div 2
    src_sel = 1'b0; scale = 3'd0; grp_fast_en = 1'b1; run_en = 1'b1;
    @(negedge clk);
    pulse(1'b1, 1'b0, t);
    chk(t == 1'b0, "R1 first strobe no tick", t, 0);
    pulse(1'b1, 1'b0, t);
    chk(t == 1'b1, "R1 second strobe tick", t, 1);

    // R2 R3 R4 R7 table walk
    for (int i = 0; i < 16; i++) begin
      int ticks;
      int first;
      logic [32:0] v;
      v = VEC[i];
      setup(v[32], v[31:29]);
      ticks = 0;
      first = 0;
      for (int k = 1; k <= int'(v[28:16]); k++) begin
        pulse(1'b1, 1'b1, t);
        if (t) begin
          ticks++;
          if (first == 0) first = k;
        end
      end
      chk(ticks == int'(v[15:13]), v[32] ? "R3 tick count" : "R2 tick count",
          ticks, int'(v[15:13]));
      chk(first == int'(v[12:0]), "R4 first tick strobe", first, int'(v[12:0]));
    end

    // R5 run enable low
    setup(1'b1, 3'd0);
    run_en = 1'b0;
    burst(1'b1, 1'b1, 10, cnt);
    chk(cnt == 0, "R5 no tick while disabled", cnt, 0);

    // R5 disable clears count: fast div 8
    setup(1'b0, 3'd1);
    burst(1'b1, 1'b0, 5, cnt);
    @(negedge clk); run_en = 1'b0;
    @(negedge clk); run_en = 1'b1;
    burst(1'b1, 1'b0, 7, cnt);
    chk(cnt == 0, "R5 count cleared by disable", cnt, 0);
    burst(1'b1, 1'b0, 1, cnt);
    chk(cnt == 1, "R5 tick after full period", cnt, 1);

    // R6 fast group off holds count
    setup(1'b0, 3'd1);
    burst(1'b1, 1'b0, 5, cnt);
    grp_fast_en = 1'b0;
    burst(1'b1, 1'b0, 10, cnt);
    chk(cnt == 0, "R6 fast group off", cnt, 0);
    grp_fast_en = 1'b1;
    burst(1'b1, 1'b0, 2, cnt);
    chk(cnt == 0, "R6 held count resumes", cnt, 0);
    burst(1'b1, 1'b0, 1, cnt);
    chk(cnt == 1, "R6 tick on eighth strobe", cnt, 1);

    // R6 slow group off
    setup(1'b1, 3'd0);
    grp_slow_en = 1'b0;
    burst(1'b0, 1'b1, 6, cnt);
    chk(cnt == 0, "R6 slow group off", cnt, 0);

    // R7 unselected source ignored
    setup(1'b1, 3'd0);
    burst(1'b1, 1'b0, 6, cnt);
    chk(cnt == 0, "R7 fast strobes ignored on slow", cnt, 0);
    setup(1'b0, 3'd0);
    burst(1'b0, 1'b1, 6, cnt);
    chk(cnt == 0, "R7 slow strobes ignored on fast", cnt, 0);

    // R8 configuration change clears count
    setup(1'b0, 3'd1);
    burst(1'b1, 1'b1, 6, cnt);
    @(negedge clk);
    src_sel = 1'b1;
    scale = 3'd3;
    burst(1'b1, 1'b1, 7, cnt);
    chk(cnt == 0, "R8 no early tick after change", cnt, 0);
    burst(1'b1, 1'b1, 1, cnt);
    chk(cnt == 1, "R8 tick after full new period", cnt, 1);

    // R8 strobe in change cycle not counted: slow div 2
    setup(1'b1, 3'd0);
    @(negedge clk);
    scale = 3'd1;
    slow_stb = 1'b1;
    @(negedge clk);
    slow_stb = 1'b0;
    burst(1'b0, 1'b1, 1, cnt);
    chk(cnt == 0, "R8 change-cycle strobe dropped", cnt, 0);
    burst(1'b0, 1'b1, 1, cnt);
    chk(cnt == 1, "R8 tick on second later strobe", cnt, 1);

    // R4 held strobe under divide by 1
    setup(1'b1, 3'd0);
    @(negedge clk);
    slow_stb = 1'b1;
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    slow_stb = 1'b0;
    @(negedge clk);
    chk(cnt == 3, "R4 tick every held cycle", cnt, 3);
    @(negedge clk);
    chk(tick == 1'b0, "R4 tick drops after strobe", tick, 0);

    // R4 single-cycle ticks throughout
    chk(stray == 0, "R4 tick lasted more than one cycle", stray, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule